// File: doc/BRIEF.md
# Host Command Register Bank with Magnitude Detector

This block turns host command words into live configuration inside the processing clock domain. Each cycle that the command strobe is high, an 8-bit opcode selects the destination and a 16-bit value supplies the data. Most opcodes write a configuration register: the operating mode, the detection threshold, a three-bit stream-enable mask, five chirp timing cycle counts and the number of chirps per elevation. Two opcodes do not store anything. Instead, each one fires a one-cycle pulse: one for the single-shot trigger and one for the status request. Opcodes that are not listed are ignored.

The same block holds a small detector. It takes a signed complex sample (I, Q) and forms |I|+|Q| with one extra bit of headroom. It then compares that sum against the threshold that is programmed at the moment of comparison. Each detection raises a one-cycle flag and advances a detection counter. Command transport and clock-domain crossing happen upstream of this block.

Top module: `hostcfg_bank`

## Requirements
- R1: After reset, the outputs hold these values:
  - mode: 2'b00
  - threshold: 10000
  - stream enable: 3'b111
  - timing values: long chirp 3000, long listen 13700, guard 17540, short chirp 50, short listen 17450
  - chirps per elevation: 32
  - both pulses: low
  - detection flag: low
  - detection count: 0
- R2: A command writes a register on the clock edge where the strobe is high, and the new value is visible on the next cycle. Opcode 0x01 stores value[1:0] as the mode. Opcode 0x03 stores all 16 bits as the threshold. Opcode 0x04 stores value[2:0] as the stream enable.
- R3: Opcodes 0x10, 0x11, 0x12, 0x13 and 0x14 store the full value, in that order, into long chirp, long listen, guard, short chirp and short listen. Opcode 0x15 stores value[5:0] as chirps per elevation.
- R4: A single command with opcode 0x02 makes the trigger output high for exactly the next cycle. A single command with opcode 0xFF does the same on the status-request output. Neither opcode changes any stored register.
- R5: Pulse commands on consecutive cycles keep the matching pulse high for each of those cycles. The pulse falls in the first cycle that follows a non-matching command or an idle cycle.
- R6: These cases leave every register and both pulses unchanged or low:
  - a strobe with any opcode outside {0x01, 0x02, 0x03, 0x04, 0x10 to 0x15, 0xFF};
  - any cycle with the strobe low.
- R7: The magnitude is |I|+|Q| taken from two signed 16-bit samples, as a 17-bit value. This holds even when both are -32768 (magnitude 65536).
- R8: A sample is accepted with the sample strobe high. Two cycles later the detection flag is high if the magnitude is strictly greater than the zero-extended threshold. A magnitude equal to the threshold does not detect. Otherwise the flag is low.
- R9: The detection count goes up by one in each cycle the detection flag is high, and stays the same in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOpcode | input | 8 | Command opcode |
| cmdValue | input | 16 | Command value |
| sampleValid | input | 1 | Sample strobe |
| sampleI | input | 16 | Signed in-phase sample |
| sampleQ | input | 16 | Signed quadrature sample |
| radarMode | output | 2 | Operating mode field |
| triggerPulse | output | 1 | One-cycle trigger pulse |
| detThreshold | output | 16 | Detection threshold |
| streamEnable | output | 3 | Stream-enable mask |
| longChirpCycles | output | 16 | Long chirp cycle count |
| longListenCycles | output | 16 | Long listen cycle count |
| guardCycles | output | 16 | Guard cycle count |
| shortChirpCycles | output | 16 | Short chirp cycle count |
| shortListenCycles | output | 16 | Short listen cycle count |
| chirpsPerElev | output | 6 | Chirps per elevation |
| statusReqPulse | output | 1 | One-cycle status-request pulse |
| detectFlag | output | 1 | Registered detection flag |
| detectCount | output | 16 | Detection counter |

## Verification
The hardest case to reach is the top of the magnitude range. Both samples at -32768 produce 65536, a value one bit wider than any threshold can be. A sum of 65535 must tie a maximum threshold and not detect. The stimulus first programs the threshold to 0xFFFF through the command port. It then sends those two samples back to back, after a pair at 300 that sits exactly on a smaller threshold and a pair just above it. Pulse restart is covered by sending runs of trigger and status opcodes on consecutive cycles and breaking them with an unlisted opcode.

// File: rtl/hostcfg_pkg.sv
package hostcfg_pkg;

  localparam int OPC_W      = 8;
  localparam int VAL_W      = 16;
  localparam int MODE_W     = 2;
  localparam int STREAM_W   = 3;
  localparam int CPE_W      = 6;
  localparam int NUM_TIMING = 5;

  // Opcode assignments; timing opcodes are consecutive from the base, in
  // the order long chirp, long listen, guard, short chirp, short listen.
  localparam logic [OPC_W-1:0] OP_MODE        = 8'h01;
  localparam logic [OPC_W-1:0] OP_TRIG        = 8'h02;
  localparam logic [OPC_W-1:0] OP_THR         = 8'h03;
  localparam logic [OPC_W-1:0] OP_STREAM      = 8'h04;
  localparam logic [OPC_W-1:0] OP_TIMING_BASE = 8'h10;
  localparam logic [OPC_W-1:0] OP_CPE         = 8'h15;
  localparam logic [OPC_W-1:0] OP_STATUS      = 8'hFF;

  // Strobes from command decode to the register datapath.
  typedef struct packed {
    logic                  setMode;
    logic                  setThr;
    logic                  setStream;
    logic [NUM_TIMING-1:0] setTiming;
    logic                  setCpe;
    logic                  fireTrig;
    logic                  fireStatus;
  } cmdStrobes_t;

endpackage

// File: rtl/hostcfg_decode.sv
module hostcfg_decode
  import hostcfg_pkg::*;
(
  input  logic             cmdValid,
  input  logic [OPC_W-1:0] cmdOpcode,
  output cmdStrobes_t      strobes
);

  logic [NUM_TIMING-1:0] timingHit;

  for (genvar k = 0; k < NUM_TIMING; k++) begin : g_timingHit
    assign timingHit[k] = (cmdOpcode == OPC_W'(int'(OP_TIMING_BASE) + k));
  end

  always_comb begin
    strobes = '0;
    if (cmdValid) begin
      strobes.setTiming = timingHit;
      case (cmdOpcode)
        OP_MODE:   strobes.setMode    = 1'b1;
        OP_TRIG:   strobes.fireTrig   = 1'b1;
        OP_THR:    strobes.setThr     = 1'b1;
        OP_STREAM: strobes.setStream  = 1'b1;
        OP_CPE:    strobes.setCpe     = 1'b1;
        OP_STATUS: strobes.fireStatus = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/hostcfg_regs.sv
module hostcfg_regs
  import hostcfg_pkg::*;
#(
  parameter logic [MODE_W-1:0]                  DEF_MODE   = '0,
  parameter logic [VAL_W-1:0]                   DEF_THR    = 16'd10000,
  parameter logic [STREAM_W-1:0]                DEF_STREAM = 3'b111,
  parameter logic [NUM_TIMING-1:0][VAL_W-1:0]   DEF_TIMING = {16'd17450, 16'd50, 16'd17540, 16'd13700, 16'd3000},
  parameter logic [CPE_W-1:0]                   DEF_CPE    = 6'd32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  cmdStrobes_t                          strobes,
  input  logic [VAL_W-1:0]                     cmdValue,
  output logic [MODE_W-1:0]                    modeQ,
  output logic [VAL_W-1:0]                     thrQ,
  output logic [STREAM_W-1:0]                  streamQ,
  output logic [NUM_TIMING-1:0][VAL_W-1:0]     timingQ,
  output logic [CPE_W-1:0]                     cpeQ,
  output logic                                 trigQ,
  output logic                                 statusQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= DEF_MODE;
      thrQ    <= DEF_THR;
      streamQ <= DEF_STREAM;
      cpeQ    <= DEF_CPE;
      trigQ   <= 1'b0;
      statusQ <= 1'b0;
    end else begin
      // Pulses re-arm from each cycle's decode, so a run of commands
      // holds them high and the first other cycle drops them.
      trigQ   <= strobes.fireTrig;
      statusQ <= strobes.fireStatus;
      if (strobes.setMode)   modeQ   <= cmdValue[MODE_W-1:0];
      if (strobes.setThr)    thrQ    <= cmdValue;
      if (strobes.setStream) streamQ <= cmdValue[STREAM_W-1:0];
      if (strobes.setCpe)    cpeQ    <= cmdValue[CPE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timingQ <= DEF_TIMING;
    end else begin
      for (int k = 0; k < NUM_TIMING; k++) begin
        if (strobes.setTiming[k]) timingQ[k] <= cmdValue;
      end
    end
  end

  // R6: decode never asks for two destinations at once
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/hostcfg_detect.sv
module hostcfg_detect #(
  parameter int SAMP_W = 16,
  parameter int THR_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [SAMP_W-1:0] sampleI,
  input  logic signed [SAMP_W-1:0] sampleQ,
  input  logic [THR_W-1:0]         threshold,
  output logic                     detectFlag,
  output logic [CNT_W-1:0]         detectCount
);

  localparam int MAG_W = SAMP_W + 1;

  function automatic logic [MAG_W-1:0] absExt(input logic signed [SAMP_W-1:0] x);
    logic [MAG_W-1:0] e;
    e = {x[SAMP_W-1], x};
    return x[SAMP_W-1] ? (~e + 1'b1) : e;
  endfunction

  logic [MAG_W-1:0] magQ;
  logic             magValidQ;
  logic             hit;

  assign hit = magValidQ && (magQ > MAG_W'(threshold));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magQ        <= '0;
      magValidQ   <= 1'b0;
      detectFlag  <= 1'b0;
      detectCount <= '0;
    end else begin
      magValidQ  <= sampleValid;
      if (sampleValid) magQ <= absExt(sampleI) + absExt(sampleQ);
      detectFlag <= hit;
      if (hit) detectCount <= detectCount + 1'b1;
    end
  end

  // R9: counter only moves alongside a raised flag
  a_r9_count_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    (detectCount != $past(detectCount)) |-> detectFlag);

  // R8: a flag always traces back to a sample two cycles earlier
  a_r8_flag_from_sample: assert property (@(posedge clk) disable iff (!rstN)
    detectFlag |-> $past(sampleValid, 2));

endmodule

// File: rtl/hostcfg_bank.sv
module hostcfg_bank
  import hostcfg_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [OPC_W-1:0]         cmdOpcode,
  input  logic [VAL_W-1:0]         cmdValue,
  input  logic                     sampleValid,
  input  logic signed [SAMP_W-1:0] sampleI,
  input  logic signed [SAMP_W-1:0] sampleQ,
  output logic [MODE_W-1:0]        radarMode,
  output logic                     triggerPulse,
  output logic [VAL_W-1:0]         detThreshold,
  output logic [STREAM_W-1:0]      streamEnable,
  output logic [VAL_W-1:0]         longChirpCycles,
  output logic [VAL_W-1:0]         longListenCycles,
  output logic [VAL_W-1:0]         guardCycles,
  output logic [VAL_W-1:0]         shortChirpCycles,
  output logic [VAL_W-1:0]         shortListenCycles,
  output logic [CPE_W-1:0]         chirpsPerElev,
  output logic                     statusReqPulse,
  output logic                     detectFlag,
  output logic [CNT_W-1:0]         detectCount
);

  cmdStrobes_t                       strobes;
  logic [NUM_TIMING-1:0][VAL_W-1:0]  timingQ;

  hostcfg_decode u_decode (
    .cmdValid  (cmdValid),
    .cmdOpcode (cmdOpcode),
    .strobes   (strobes)
  );

  hostcfg_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmdValue (cmdValue),
    .modeQ    (radarMode),
    .thrQ     (detThreshold),
    .streamQ  (streamEnable),
    .timingQ  (timingQ),
    .cpeQ     (chirpsPerElev),
    .trigQ    (triggerPulse),
    .statusQ  (statusReqPulse)
  );

  assign longChirpCycles   = timingQ[0];
  assign longListenCycles  = timingQ[1];
  assign guardCycles       = timingQ[2];
  assign shortChirpCycles  = timingQ[3];
  assign shortListenCycles = timingQ[4];

  hostcfg_detect #(
    .SAMP_W (SAMP_W),
    .THR_W  (VAL_W),
    .CNT_W  (CNT_W)
  ) u_detect (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleI     (sampleI),
    .sampleQ     (sampleQ),
    .threshold   (detThreshold),
    .detectFlag  (detectFlag),
    .detectCount (detectCount)
  );

  // Port-level checks against an independent opcode list.
  logic opKnown;
  logic [VAL_W*6+MODE_W+STREAM_W+CPE_W-1:0] cfgAll;

  assign opKnown = (cmdOpcode == 8'h01) || (cmdOpcode == 8'h02) ||
                   (cmdOpcode == 8'h03) || (cmdOpcode == 8'h04) ||
                   (cmdOpcode == 8'hFF) ||
                   ((cmdOpcode >= 8'h10) && (cmdOpcode <= 8'h15));
  assign cfgAll  = {radarMode, detThreshold, streamEnable, longChirpCycles,
                    longListenCycles, guardCycles, shortChirpCycles,
                    shortListenCycles, chirpsPerElev};

  // R4: trigger opcode is followed by the pulse
  a_r4_trig_follows: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == 8'h02) |=> triggerPulse);

  // R4: status opcode is followed by the pulse
  a_r4_status_follows: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == 8'hFF) |=> statusReqPulse);

  // R5: a pulse never outlives the command that started it
  a_r5_trig_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    triggerPulse |-> $past(cmdValid && cmdOpcode == 8'h02));

  a_r5_status_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    statusReqPulse |-> $past(cmdValid && cmdOpcode == 8'hFF));

  // R6: idle cycles and unlisted opcodes change no register
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(cfgAll));

  a_r6_unlisted_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !opKnown) |=> ($stable(cfgAll) && !triggerPulse && !statusReqPulse));

endmodule

// File: tb/hostcfg_bank_tb_top.sv
`timescale 1ns/1ps
module hostcfg_bank_tb_top;

  localparam int SNAP_W = 109;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOpcode = '0;
  logic [15:0] cmdValue = '0;
  logic        sampleValid = 1'b0;
  logic signed [15:0] sampleI = '0;
  logic signed [15:0] sampleQ = '0;

  logic [1:0]  radarMode;
  logic        triggerPulse;
  logic [15:0] detThreshold;
  logic [2:0]  streamEnable;
  logic [15:0] longChirpCycles, longListenCycles, guardCycles;
  logic [15:0] shortChirpCycles, shortListenCycles;
  logic [5:0]  chirpsPerElev;
  logic        statusReqPulse;
  logic        detectFlag;
  logic [15:0] detectCount;

  always #2.5 clk = ~clk;

  hostcfg_bank dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .cmdValue(cmdValue), .sampleValid(sampleValid), .sampleI(sampleI),
    .sampleQ(sampleQ), .radarMode(radarMode), .triggerPulse(triggerPulse),
    .detThreshold(detThreshold), .streamEnable(streamEnable),
    .longChirpCycles(longChirpCycles), .longListenCycles(longListenCycles),
    .guardCycles(guardCycles), .shortChirpCycles(shortChirpCycles),
    .shortListenCycles(shortListenCycles), .chirpsPerElev(chirpsPerElev),
    .statusReqPulse(statusReqPulse), .detectFlag(detectFlag),
    .detectCount(detectCount)
  );

  int checkCnt = 0;
  int failCnt  = 0;
  int cyc      = 0;
  bit doneFlag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [SNAP_W-1:0] act, input logic [SNAP_W-1:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model of the programmed state.
  logic [1:0]  mMode = 2'b00;
  logic        mTrig = 1'b0;
  logic [15:0] mThr = 16'd10000;
  logic [2:0]  mStream = 3'b111;
  logic [15:0] mTim [5] = '{16'd3000, 16'd13700, 16'd17540, 16'd50, 16'd17450};
  logic [5:0]  mCpe = 6'd32;
  logic        mStat = 1'b0;
  logic [15:0] mCount = '0;

  function automatic logic [SNAP_W-1:0] modelSnap();
    return {mMode, mTrig, mThr, mStream, mTim[4], mTim[3], mTim[2], mTim[1],
            mTim[0], mCpe, mStat};
  endfunction

  function automatic logic [SNAP_W-1:0] portSnap();
    return {radarMode, triggerPulse, detThreshold, streamEnable, shortListenCycles,
            shortChirpCycles, guardCycles, longListenCycles, longChirpCycles,
            chirpsPerElev, statusReqPulse};
  endfunction

  typedef struct {
    int                due;
    string             tag;
    logic [SNAP_W-1:0] snap;
  } cfgItem_t;

  typedef struct {
    int          due;
    string       tag;
    logic        flag;
    logic [15:0] count;
  } detItem_t;

  cfgItem_t cfgQ[$];
  detItem_t detQ[$];

  // Driver tasks: drive at the falling edge, push what the next edges must show.
  task automatic sendCmd(input logic [7:0] op, input logic [15:0] val, input string tag);
    cfgItem_t it;
    @(negedge clk);
    cmdValid = 1'b1; cmdOpcode = op; cmdValue = val;
    mTrig = (op == 8'h02);
    mStat = (op == 8'hFF);
    case (op)
      8'h01: mMode = val[1:0];
      8'h03: mThr = val;
      8'h04: mStream = val[2:0];
      8'h10, 8'h11, 8'h12, 8'h13, 8'h14: mTim[op - 8'h10] = val;
      8'h15: mCpe = val[5:0];
      default: ;
    endcase
    it.due = cyc + 1; it.tag = tag; it.snap = modelSnap();
    cfgQ.push_back(it);
  endtask

  task automatic idleCmd(input string tag);
    cfgItem_t it;
    @(negedge clk);
    cmdValid = 1'b0; cmdOpcode = 8'h02; cmdValue = 16'hFFFF;
    mTrig = 1'b0; mStat = 1'b0;
    it.due = cyc + 1; it.tag = tag; it.snap = modelSnap();
    cfgQ.push_back(it);
  endtask

  function automatic logic [16:0] absRef(input int v);
    return 17'(v < 0 ? -v : v);
  endfunction

  task automatic sendSample(input int i, input int q, input string tag);
    detItem_t it;
    logic [16:0] mag;
    @(negedge clk);
    sampleValid = 1'b1; sampleI = 16'(i); sampleQ = 16'(q);
    mag = absRef(i) + absRef(q);
    it.flag = (mag > {1'b0, mThr});
    if (it.flag) mCount = mCount + 1'b1;
    it.due = cyc + 2; it.tag = tag; it.count = mCount;
    detQ.push_back(it);
  endtask

  task automatic endSamples(input string tag);
    detItem_t it;
    @(negedge clk);
    sampleValid = 1'b0; sampleI = 16'sh7FFF; sampleQ = 16'sh7FFF;
    it.due = cyc + 2; it.tag = tag; it.flag = 1'b0; it.count = mCount;
    detQ.push_back(it);
  endtask

  // Monitor: pop items that fall due and compare against the ports.
  always @(negedge clk) begin
    while (cfgQ.size() > 0 && cfgQ[0].due == cyc) begin
      cfgItem_t it;
      it = cfgQ.pop_front();
      check(portSnap() === it.snap, it.tag, "config snapshot", portSnap(), it.snap);
    end
    while (detQ.size() > 0 && detQ[0].due == cyc) begin
      detItem_t it;
      it = detQ.pop_front();
      check(detectFlag === it.flag, it.tag, "detect flag",
            SNAP_W'(detectFlag), SNAP_W'(it.flag));
      check(detectCount === it.count, "R9", "detect count",
            SNAP_W'(detectCount), SNAP_W'(it.count));
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!doneFlag) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(portSnap() === modelSnap(), "R1", "reset config", portSnap(), modelSnap());
    check(detectFlag === 1'b0, "R1", "reset flag", SNAP_W'(detectFlag), '0);
    check(detectCount === 16'd0, "R1", "reset count", SNAP_W'(detectCount), '0);

    idleCmd("R6");
    // R2: mode, stream, threshold
    sendCmd(8'h01, 16'hFFFE, "R2");
    sendCmd(8'h04, 16'hFFFA, "R2");
    sendCmd(8'h03, 16'd300, "R2");
    idleCmd("R6");
    // R3: timing order and chirps per elevation
    sendCmd(8'h10, 16'h1111, "R3");
    sendCmd(8'h11, 16'h2222, "R3");
    sendCmd(8'h12, 16'h3333, "R3");
    sendCmd(8'h13, 16'h4444, "R3");
    sendCmd(8'h14, 16'h5555, "R3");
    sendCmd(8'h15, 16'hFFC7, "R3");
    idleCmd("R6");
    // R4: isolated pulses
    sendCmd(8'h02, 16'h1234, "R4");
    idleCmd("R4");
    sendCmd(8'hFF, 16'hABCD, "R4");
    idleCmd("R4");
    // R5: back-to-back pulse commands
    sendCmd(8'h02, 16'h0000, "R5");
    sendCmd(8'h02, 16'h0000, "R5");
    sendCmd(8'hFF, 16'h0000, "R5");
    sendCmd(8'hFF, 16'h0000, "R5");
    sendCmd(8'h02, 16'h0000, "R5");
    sendCmd(8'h05, 16'h0000, "R5");
    idleCmd("R5");
    // R6: unlisted opcodes
    sendCmd(8'h00, 16'hBEEF, "R6");
    sendCmd(8'h05, 16'hBEEF, "R6");
    sendCmd(8'h0F, 16'hBEEF, "R6");
    sendCmd(8'h16, 16'hBEEF, "R6");
    sendCmd(8'h20, 16'hBEEF, "R6");
    sendCmd(8'hFE, 16'hBEEF, "R6");
    idleCmd("R6");
    // R7/R8 at threshold 300
    sendSample(-100, 200, "R8");
    sendSample(-101, 200, "R7");
    sendSample(100, -201, "R7");
    sendSample(0, 0, "R8");
    sendSample(-150, -151, "R8");
    endSamples("R8");
    repeat (3) @(negedge clk);
    // R7/R8 at the top of the range
    sendCmd(8'h03, 16'hFFFF, "R2");
    idleCmd("R6");
    sendSample(-32768, -32768, "R7");
    sendSample(32767, -32768, "R8");
    sendSample(-32768, 0, "R8");
    sendSample(-32768, -32768, "R7");
    endSamples("R8");
    repeat (6) @(negedge clk);
    doneFlag = 1'b1;
    if (cfgQ.size() != 0 || detQ.size() != 0) begin
      checkCnt++; failCnt++;
      $display("FAIL R9 pending items: actual=%0d expected=0", cfgQ.size() + detQ.size());
    end
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule